// File: doc/BRIEF.md
# Per-Pin GPIO Configuration Register Bank

This block holds one 32-bit control word for each of a parameterised number of pins and serves them over a small word-addressed register bus. Each word combines the pin's output data, a 3-bit mode, a 2-bit function select, an interrupt-group select, a lock bit and some pad settings. The mode sets the pin's direction and also its interrupt trigger type. The pad settings (pull, input enable, Schmitt enable and both drive-strength fields) are only stored.

The block drives each pad's output value, output enable and function select. When the function select is zero, the pin is under GPIO control, and output enable follows the mode. When the select is non-zero, the pad takes its output and enable from one of three peripheral inputs. Pin inputs pass through a two-flop synchroniser. The synchronised level is exported, together with every pin's mode and group fields, to a separate interrupt unit.

A read of a pin word returns the synchronised pin level in bit 0 whenever the pin is not in output mode. Otherwise bit 0 holds the stored data value.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset every pin word reads 0x0000000E (mode 7, all other fields 0), every output enable is low and every function select is 0.
- R2: A write stores only the defined bits (mask 0x00E78FEF: bit 0 data, bits 3:1 mode, bits 6:5 function select, bits 8:7 pull, bit 9 input enable, bits 11:10 and 23:22 drive, bit 15 Schmitt, bits 18:16 group, bit 21 lock). Reserved bits read back as 0. The word of pin n is at byte address 4*n.
- R3: When the mode field is not 1, read bit 0 is the synchronised pin level. When the mode is 1, read bit 0 is the stored data bit.
- R4: With function select 0, output enable is high exactly when the mode is 1, and the pad output equals the stored data bit.
- R5: With function select f in 1..3, pad output and enable of pin p equal periph_out_i and periph_oe_i at index 3*p+f-1.
- R6: Once a word's lock bit (bit 21) is stored as 1, writes to that word are ignored until reset.
- R7: Writes to word indices at or above NUM_PINS change nothing, and reads there return 0.
- R8: mode_o and group_o carry each pin's stored mode (3 bits at 3*p) and group (3 bits at 3*p).
- R9: Read data appears on rdata_o with rvalid_o high in the cycle after a read request, and rvalid_o is low after any cycle without one.
- R10: sync_o is pin_in_i delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address; word index in bits ADDR_W-1:2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| pin_in_i | input | NUM_PINS | Raw pad input levels |
| pin_out_o | output | NUM_PINS | Pad output values |
| pin_oe_o | output | NUM_PINS | Pad output enables |
| func_sel_o | output | 2*NUM_PINS | Per-pin function select to the pad mux |
| periph_out_i | input | 3*NUM_PINS | Peripheral output values, three per pin |
| periph_oe_i | input | 3*NUM_PINS | Peripheral output enables, three per pin |
| sync_o | output | NUM_PINS | Synchronised pin levels for interrupt detection |
| mode_o | output | 3*NUM_PINS | Per-pin mode field |
| group_o | output | 3*NUM_PINS | Per-pin interrupt group field |

## Verification
The assertions assume a bus that changes its inputs only between clock edges, and pin inputs that stay at a level long enough for the two-edge synchroniser window to be meaningful. The bench drives every bus and pin input at the falling edge and samples outputs one falling edge later, so each registered result has settled. Peripheral inputs are static patterns that are set before each pad check. Out-of-range accesses use indices just above the last pin and well beyond it, which exercises the range comparison without any address aliasing.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int          WORD_W     = 32;
  localparam int          PERIPH_CNT = 3;
  localparam int          FSEL_W     = 2;
  localparam int          MODE_W     = 3;
  localparam int          GRP_W      = 3;
  localparam int          DATA_BIT   = 0;
  localparam int          MODE_LSB   = 1;
  localparam int          FSEL_LSB   = 5;
  localparam int          GRP_LSB    = 16;
  localparam int          LOCK_BIT   = 21;
  localparam logic [31:0] FIELD_MASK = 32'h00E7_8FEF;
  localparam logic [31:0] RESET_WORD = 32'h0000_000E;
  localparam logic [2:0]  MODE_OUT   = 3'd1;

  function automatic logic [MODE_W-1:0] mode_of(input logic [WORD_W-1:0] w);
    return w[MODE_LSB +: MODE_W];
  endfunction

  function automatic logic [FSEL_W-1:0] fsel_of(input logic [WORD_W-1:0] w);
    return w[FSEL_LSB +: FSEL_W];
  endfunction

  function automatic logic [GRP_W-1:0] grp_of(input logic [WORD_W-1:0] w);
    return w[GRP_LSB +: GRP_W];
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_word.sv
module gpio_pin_word
  import gpio_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              lock_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          word_q <= RESET_WORD;
    else if (wr_en_i && !word_q[LOCK_BIT]) word_q <= wdata_i & FIELD_MASK;
  end

  assign word_o = word_q;
  assign lock_o = word_q[LOCK_BIT];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_cfg_pkg::*;
(
  input  logic [FSEL_W-1:0]     fsel_i,
  input  logic [MODE_W-1:0]     mode_i,
  input  logic                  data_i,
  input  logic [PERIPH_CNT-1:0] periph_out_i,
  input  logic [PERIPH_CNT-1:0] periph_oe_i,
  output logic                  pad_out_o,
  output logic                  pad_oe_o
);
  logic [FSEL_W-1:0] sel;
  assign sel = fsel_i - 1'b1;

  always_comb begin
    pad_out_o = data_i;
    pad_oe_o  = (mode_i == MODE_OUT);
    if (fsel_i != '0) begin
      pad_out_o = periph_out_i[sel];
      pad_oe_o  = periph_oe_i[sel];
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  output logic                           rvalid_o,
  input  logic [NUM_PINS-1:0]            pin_in_i,
  output logic [NUM_PINS-1:0]            pin_out_o,
  output logic [NUM_PINS-1:0]            pin_oe_o,
  output logic [2*NUM_PINS-1:0]          func_sel_o,
  input  logic [PERIPH_CNT*NUM_PINS-1:0] periph_out_i,
  input  logic [PERIPH_CNT*NUM_PINS-1:0] periph_oe_i,
  output logic [NUM_PINS-1:0]            sync_o,
  output logic [3*NUM_PINS-1:0]          mode_o,
  output logic [3*NUM_PINS-1:0]          group_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              unused_addr_lsb;
  logic [WORD_W-1:0] word_q [NUM_PINS];
  logic [NUM_PINS-1:0] lock_vec;
  logic [NUM_PINS-1:0] sync_q;
  logic [WORD_W-1:0] rd_word;

  assign idx             = addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^addr_i[1:0];

  gpio_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (sync_q)
  );
  assign sync_o = sync_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic wr_en;
    assign wr_en = req_i && we_i && (idx == IDX_W'(p));

    gpio_pin_word i_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_en),
      .wdata_i(wdata_i),
      .word_o (word_q[p]),
      .lock_o (lock_vec[p])
    );

    gpio_pad_mux i_pad (
      .fsel_i      (fsel_of(word_q[p])),
      .mode_i      (mode_of(word_q[p])),
      .data_i      (word_q[p][DATA_BIT]),
      .periph_out_i(periph_out_i[PERIPH_CNT*p +: PERIPH_CNT]),
      .periph_oe_i (periph_oe_i[PERIPH_CNT*p +: PERIPH_CNT]),
      .pad_out_o   (pin_out_o[p]),
      .pad_oe_o    (pin_oe_o[p])
    );

    assign func_sel_o[FSEL_W*p +: FSEL_W] = fsel_of(word_q[p]);
    assign mode_o[MODE_W*p +: MODE_W]     = mode_of(word_q[p]);
    assign group_o[GRP_W*p +: GRP_W]      = grp_of(word_q[p]);
  end

  // Non-output pins report the live synchronised level in the data bit.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_word = word_q[i];
        if (mode_of(word_q[i]) != MODE_OUT) rd_word[DATA_BIT] = sync_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_word;
    end
  end
endmodule

// File: rtl/gpio_cfg_checker.sv
module gpio_cfg_checker #(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [IDX_W-1:0]      idx_i,
  input logic [31:0]           rdata_o,
  input logic                  rvalid_o,
  input logic [NUM_PINS-1:0]   pin_in_i,
  input logic [NUM_PINS-1:0]   sync_o,
  input logic [NUM_PINS-1:0]   pin_oe_o,
  input logic [2*NUM_PINS-1:0] func_sel_o,
  input logic [3*NUM_PINS-1:0] mode_o,
  input logic [3*NUM_PINS-1:0] group_o,
  input logic [NUM_PINS-1:0]   lock_vec
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  assert_rvalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_rvalid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  assert_oor_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (32'(idx_i) >= NUM_PINS)) |=> (rdata_o == 32'h0));

  assert_sync_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (sync_o == $past(pin_in_i, 2)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assert_oe_gpio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_sel_o[2*p +: 2] == 2'd0 && mode_o[3*p +: 3] != 3'd1) |-> !pin_oe_o[p]);

    assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_vec[p] |=> (lock_vec[p] && $stable(mode_o[3*p +: 3]) &&
                       $stable(group_o[3*p +: 3]) && $stable(func_sel_o[2*p +: 2])));
  end
endmodule

bind gpio_cfg_bank gpio_cfg_checker #(
  .NUM_PINS(NUM_PINS),
  .IDX_W   (ADDR_W - 2)
) i_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .idx_i     (addr_i[ADDR_W-1:2]),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .pin_in_i  (pin_in_i),
  .sync_o    (sync_o),
  .pin_oe_o  (pin_oe_o),
  .func_sel_o(func_sel_o),
  .mode_o    (mode_o),
  .group_o   (group_o),
  .lock_vec  (lock_vec)
);

// File: tb/test_gpio_cfg_bank.sv
`timescale 1ns/1ps
module test_gpio_cfg_bank;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam logic [31:0] MASK = 32'h00E7_8FEF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          rvalid;
  logic [N-1:0]  pin_in, pin_out, pin_oe, sync;
  logic [2*N-1:0] fsel;
  logic [3*N-1:0] p_out, p_oe, mode, grp;

  int checks = 0;
  int errors = 0;

  gpio_cfg_bank #(.NUM_PINS(N), .ADDR_W(AW)) i_gpio_cfg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .func_sel_o(fsel),
    .periph_out_i(p_out), .periph_oe_i(p_oe), .sync_o(sync),
    .mode_o(mode), .group_o(grp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(idx * 4); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(idx * 4);
    @(negedge clk);
    req = 1'b0;
    chk("R9 rvalid", 32'(rvalid), 32'd1);
    d = rdata;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_ni = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    pin_in = '0; p_out = '0; p_oe = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    chk("R1 oe", 32'(pin_oe), 32'h0);
    chk("R1 fsel", 32'(fsel), 32'h0);
    for (int i = 0; i < N; i++) begin
      rd(i, v); chk("R1 word", v, 32'hE);
    end
    @(negedge clk);
    chk("R9 idle rvalid", 32'(rvalid), 32'd0);

    // R2: field mask, output mode keeps stored data bit
    for (int i = 0; i < N; i++) begin
      logic [31:0] w;
      w = 32'hFFDF_FFF3 & ~(32'(i) << 16);
      wr(i, w);
      rd(i, v); chk("R2 mask", v, w & MASK);
    end
    for (int i = 0; i < N; i++) wr(i, 32'hE);

    // R8: exported mode and group fields
    for (int i = 0; i < N; i++) wr(i, (32'((7 - i) % 8) << 16) | (32'(i % 8) << 1));
    for (int i = 0; i < N; i++) begin
      chk("R8 mode", 32'(mode[3*i +: 3]), 32'(i % 8));
      chk("R8 group", 32'(grp[3*i +: 3]), 32'((7 - i) % 8));
    end
    for (int i = 0; i < N; i++) wr(i, 32'hE);

    // R4 / R5: pad mux sweep
    for (int p = 0; p < N; p++) begin
      for (int f = 0; f < 4; f++) begin
        for (int mi = 0; mi < 2; mi++) begin
          for (int d = 0; d < 2; d++) begin
            int m;
            logic eo, ee;
            m = mi ? 7 : 1;
            p_out = 24'(32'h5A3C96 ^ (p * 37 + f * 11 + d * 5));
            p_oe  = 24'(32'hA5C369 ^ (p * 13 + f * 29 + mi * 3));
            wr(p, (32'(f) << 5) | (32'(m) << 1) | 32'(d));
            if (f == 0) begin
              eo = d[0]; ee = (m == 1);
              chk("R4 out", 32'(pin_out[p]), 32'(eo));
              chk("R4 oe", 32'(pin_oe[p]), 32'(ee));
            end else begin
              eo = p_out[3*p + f - 1]; ee = p_oe[3*p + f - 1];
              chk("R5 out", 32'(pin_out[p]), 32'(eo));
              chk("R5 oe", 32'(pin_oe[p]), 32'(ee));
            end
          end
        end
      end
      wr(p, 32'hE);
    end

    // R10 / R3: synchroniser delay and data-bit source
    for (int p = 0; p < N; p++) begin
      @(negedge clk); pin_in = N'(1) << p;
      @(negedge clk); chk("R10 one edge", 32'(sync[p]), 32'd0);
      @(negedge clk); chk("R10 two edges", 32'(sync[p]), 32'd1);
      rd(p, v); chk("R3 live input", v, 32'hF);
      wr(p, 32'h2);
      rd(p, v); chk("R3 stored data", v, 32'h2);
      wr(p, 32'hE);
      pin_in = '0;
    end
    repeat (3) @(negedge clk);

    // R6: lock
    wr(2, 32'h0020_0003);
    chk("R6 out before", 32'(pin_out[2]), 32'd1);
    wr(2, 32'hE);
    rd(2, v); chk("R6 locked word", v, 32'h0020_0003);
    chk("R6 out held", 32'(pin_out[2]), 32'd1);
    chk("R6 oe held", 32'(pin_oe[2]), 32'd1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd(2, v); chk("R6 reset clears lock", v, 32'hE);
    wr(2, 32'h3);
    rd(2, v); chk("R6 writable after reset", v, 32'h3);
    wr(2, 32'hE);

    // R7: out of range
    wr(N, 32'h3);
    wr(N + 5, 32'h0020_0003);
    rd(N, v); chk("R7 read zero", v, 32'h0);
    rd(N + 5, v); chk("R7 read zero far", v, 32'h0);
    for (int i = 0; i < N; i++) begin
      rd(i, v); chk("R7 no alias", v, 32'hE);
    end
    chk("R7 oe untouched", 32'(pin_oe), 32'h0);

    summary();
    $finish;
  end
endmodule